// File: doc/BRIEF.md
# Multicart Outer Bank and Mode Selector

This block holds the outer banking state of a game-console multicart. It watches CPU writes. A write whose address falls in the 8 KiB window at $6000-$7FFF loads a one-bit mode flag and a three-bit outer bank number. Setting the mode flag also freezes the register: every later write is ignored until reset. The block never looks at the write-enable or write-protect setting of the inner bank controller.

Two configurations are supported:

- **Menu.** The mode flag is clear. CPU program fetches at $8000-$FFFF go to a 32 KiB menu ROM with no banking. PPU pattern fetches go to 8 KiB of CHR RAM.
- **Game.** The mode flag is set. Each side selects one of two 512 KiB game ROMs with outer bank bit 2. Bits 1..0 of the outer bank and the inner controller's bank outputs form the address within that chip. The outer bank therefore picks one 128 KiB window on the PRG side and the window with the same number on the CHR side.

The inner controller is outside this block and appears only as bank-address inputs. Every pin is a plain control or address signal. There is no streaming interface, so no valid/ready handshake or back-pressure applies.

Top module: `mc_outer_bank`

## Requirements
- R1: After reset the block is in menu mode with outer bank 0 and is unlocked: menu_cs follows CPU A15, and chr_ram_cs follows the inverse of PPU A13.
- R2: A CPU write takes part in decoding only when cpu_wr is high at a rising clock edge and cpu_addr[15:13] equals 3'b011. A write to any other address leaves the mode and the bank unchanged.
- R3: On an accepted write, data bit 4 becomes the mode (0 = menu, 1 = game) and data bits 2..0 become the outer bank. Data bits 7..5 and 3 have no effect.
- R4: Once the mode is 1 (game), every further write leaves the mode and the bank unchanged until reset.
- R5: In menu mode, menu_cs equals cpu_addr[15] and both game_prg_cs bits are 0. prg_addr equals {4'b0, cpu_addr[14:0]}.
- R6: In menu mode, chr_ram_cs equals !ppu_addr[13] and chr_ram_we equals chr_ram_cs && ppu_wr. Both game_chr_cs bits are 0, and chr_addr equals {6'b0, ppu_addr[12:0]}.
- R7: In game mode, menu_cs is 0.
  - game_prg_cs[b] is cpu_addr[15] when b equals outer bank bit 2, and 0 otherwise.
  - prg_addr equals {bank[1:0], inner_prg, cpu_addr[12:0]}.
- R8: In game mode, chr_ram_cs and chr_ram_we are 0.
  - game_chr_cs[b] is !ppu_addr[13] when b equals outer bank bit 2, and 0 otherwise.
  - chr_addr equals {bank[1:0], inner_chr, ppu_addr[9:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register loads on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Qualified CPU write strobe, one cycle per write |
| inner_prg | input | 4 | Inner controller PRG bank bits A16..A13 |
| ppu_addr | input | 14 | PPU address |
| ppu_wr | input | 1 | PPU write strobe |
| inner_chr | input | 7 | Inner controller CHR bank bits A16..A10 |
| menu_cs | output | 1 | Menu PRG ROM select |
| game_prg_cs | output | 2 | Game PRG ROM selects, one per 512 KiB chip |
| prg_addr | output | 19 | Address into the selected PRG chip |
| chr_ram_cs | output | 1 | CHR RAM select |
| chr_ram_we | output | 1 | CHR RAM write enable |
| game_chr_cs | output | 2 | Game CHR ROM selects, one per 512 KiB chip |
| chr_addr | output | 19 | Address into the selected CHR chip or RAM |

## Verification
Directed writes first exercise the decode boundary. They hit addresses just inside and just outside the $6000-$7FFF window, then send data with the ignored bits set. Together these separate a loose address decode from a loose data capture.

A menu write followed by a game write and then a second game write shows whether the lock engages on the mode bit alone. Random accesses in both modes, with random inner bank values, then separate the chip-select steering by bank bit 2 from the address concatenation. Random resets in the middle of a sequence show that the lock is cleared only by reset.

// File: rtl/mcob_pkg.sv
package mcob_pkg;
  localparam int OB_W        = 3;   // outer bank bits (A19..A17)
  localparam int MODE_BIT    = 4;   // data bit carrying the mode
  localparam int CHIP_AW     = 19;  // address width of one 512 KiB chip
  localparam int NCHIP       = 2;   // chips per side
  localparam int PRG_INNER_W = 4;   // inner PRG bank bits A16..A13
  localparam int CHR_INNER_W = 7;   // inner CHR bank bits A16..A10
  localparam int MENU_AW     = 15;  // 32 KiB menu ROM
  localparam int CRAM_AW     = 13;  // 8 KiB CHR RAM

  typedef struct packed {
    logic            game;
    logic [OB_W-1:0] bank;
  } ob_state_t;
endpackage

// File: rtl/mcob_reg.sv
module mcob_reg
  import mcob_pkg::*;
#(
  parameter logic [2:0] WIN_TAG = 3'b011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  output ob_state_t   st
);
  logic wr_hit;
  logic unused_data;

  assign wr_hit = cpu_wr && (cpu_addr[15:13] == WIN_TAG);
  assign unused_data = ^{cpu_data[7:5], cpu_data[3], cpu_addr[12:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (wr_hit && !st.game) begin
      st.game <= cpu_data[MODE_BIT];
      st.bank <= cpu_data[OB_W-1:0];
    end
  end
endmodule

// File: rtl/mcob_prg_map.sv
module mcob_prg_map
  import mcob_pkg::*;
(
  input  ob_state_t               st,
  input  logic [15:0]             cpu_addr,
  input  logic [PRG_INNER_W-1:0]  inner_prg,
  output logic                    menu_cs,
  output logic [NCHIP-1:0]        game_cs,
  output logic [CHIP_AW-1:0]      addr
);
  localparam int LOW_W  = CHIP_AW - (OB_W - 1) - PRG_INNER_W;
  localparam int MPAD_W = CHIP_AW - MENU_AW;

  logic rom_access;
  assign rom_access = cpu_addr[15];

  always_comb begin
    if (st.game) addr = {st.bank[OB_W-2:0], inner_prg, cpu_addr[LOW_W-1:0]};
    else         addr = {{MPAD_W{1'b0}}, cpu_addr[MENU_AW-1:0]};
  end

  assign menu_cs = rom_access && !st.game;

  for (genvar g = 0; g < NCHIP; g++) begin : g_cs
    assign game_cs[g] = rom_access && st.game && (st.bank[OB_W-1] == 1'(g));
  end
endmodule

// File: rtl/mcob_chr_map.sv
module mcob_chr_map
  import mcob_pkg::*;
(
  input  ob_state_t               st,
  input  logic [13:0]             ppu_addr,
  input  logic                    ppu_wr,
  input  logic [CHR_INNER_W-1:0]  inner_chr,
  output logic                    ram_cs,
  output logic                    ram_we,
  output logic [NCHIP-1:0]        game_cs,
  output logic [CHIP_AW-1:0]      addr
);
  localparam int LOW_W  = CHIP_AW - (OB_W - 1) - CHR_INNER_W;
  localparam int RPAD_W = CHIP_AW - CRAM_AW;

  logic pattern;
  assign pattern = !ppu_addr[13];

  always_comb begin
    if (st.game) addr = {st.bank[OB_W-2:0], inner_chr, ppu_addr[LOW_W-1:0]};
    else         addr = {{RPAD_W{1'b0}}, ppu_addr[CRAM_AW-1:0]};
  end

  assign ram_cs = pattern && !st.game;
  assign ram_we = ram_cs && ppu_wr;

  for (genvar g = 0; g < NCHIP; g++) begin : g_cs
    assign game_cs[g] = pattern && st.game && (st.bank[OB_W-1] == 1'(g));
  end
endmodule

// File: rtl/mc_outer_bank.sv
module mc_outer_bank
  import mcob_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            cpu_addr,
  input  logic [7:0]             cpu_data,
  input  logic                   cpu_wr,
  input  logic [PRG_INNER_W-1:0] inner_prg,
  input  logic [13:0]            ppu_addr,
  input  logic                   ppu_wr,
  input  logic [CHR_INNER_W-1:0] inner_chr,
  output logic                   menu_cs,
  output logic [NCHIP-1:0]       game_prg_cs,
  output logic [CHIP_AW-1:0]     prg_addr,
  output logic                   chr_ram_cs,
  output logic                   chr_ram_we,
  output logic [NCHIP-1:0]       game_chr_cs,
  output logic [CHIP_AW-1:0]     chr_addr
);
  ob_state_t       st;
  logic            game_mode;
  logic [OB_W-1:0] outer_bank;

  assign game_mode  = st.game;
  assign outer_bank = st.bank;

  mcob_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_wr   (cpu_wr),
    .st       (st)
  );

  mcob_prg_map u_prg (
    .st        (st),
    .cpu_addr  (cpu_addr),
    .inner_prg (inner_prg),
    .menu_cs   (menu_cs),
    .game_cs   (game_prg_cs),
    .addr      (prg_addr)
  );

  mcob_chr_map u_chr (
    .st        (st),
    .ppu_addr  (ppu_addr),
    .ppu_wr    (ppu_wr),
    .inner_chr (inner_chr),
    .ram_cs    (chr_ram_cs),
    .ram_we    (chr_ram_we),
    .game_cs   (game_chr_cs),
    .addr      (chr_addr)
  );
endmodule

// File: rtl/mcob_chk.sv
module mcob_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_data,
  input logic        cpu_wr,
  input logic        game_mode,
  input logic [2:0]  outer_bank,
  input logic        menu_cs,
  input logic [1:0]  game_prg_cs,
  input logic [18:0] prg_addr,
  input logic        chr_ram_cs,
  input logic        chr_ram_we,
  input logic [1:0]  game_chr_cs
);
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    game_mode |=> game_mode); // R4
  AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    game_mode |=> $stable(outer_bank)); // R4
  AST_OFF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] != 3'b011) |=> ($stable(outer_bank) && $stable(game_mode))); // R2
  AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!game_mode && cpu_wr && cpu_addr[15:13] == 3'b011) |=> (game_mode == $past(cpu_data[4]))); // R3
  AST_PRG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({menu_cs, game_prg_cs})); // R7
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    chr_ram_we |-> chr_ram_cs); // R6
  AST_GAME_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    game_mode |-> (!chr_ram_cs && !chr_ram_we && !menu_cs)); // R8
  AST_MENU_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    menu_cs |-> (prg_addr[14:0] == cpu_addr[14:0])); // R5
  AST_CHR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chr_ram_cs, game_chr_cs})); // R8
endmodule

bind mc_outer_bank mcob_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_data    (cpu_data),
  .cpu_wr      (cpu_wr),
  .game_mode   (game_mode),
  .outer_bank  (outer_bank),
  .menu_cs     (menu_cs),
  .game_prg_cs (game_prg_cs),
  .prg_addr    (prg_addr),
  .chr_ram_cs  (chr_ram_cs),
  .chr_ram_we  (chr_ram_we),
  .game_chr_cs (game_chr_cs)
);

// File: tb/sim_mc_outer_bank.sv
`timescale 1ns/1ps
module sim_mc_outer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [3:0]  inner_prg = '0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_wr = 1'b0;
  logic [6:0]  inner_chr = '0;
  logic        menu_cs, chr_ram_cs, chr_ram_we;
  logic [1:0]  game_prg_cs, game_chr_cs;
  logic [18:0] prg_addr, chr_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  bit       m_game = 0;
  bit [2:0] m_bank = 0;

  always #4 clk = ~clk;

  mc_outer_bank u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] e_prg_addr();
    if (m_game) return {m_bank[1:0], inner_prg, cpu_addr[12:0]};
    return {4'b0, cpu_addr[14:0]};
  endfunction

  function automatic logic [18:0] e_chr_addr();
    if (m_game) return {m_bank[1:0], inner_chr, ppu_addr[9:0]};
    return {6'b0, ppu_addr[12:0]};
  endfunction

  function automatic logic [1:0] e_gcs(bit hit);
    logic [1:0] v = 2'b00;
    if (m_game && hit) v[m_bank[2]] = 1'b1;
    return v;
  endfunction

  task automatic check_outputs(string tp, string tc);
    chk({tp, " menu_cs"}, 32'(menu_cs), 32'(!m_game && cpu_addr[15]));
    chk({tp, " game_prg_cs"}, 32'(game_prg_cs), 32'(e_gcs(cpu_addr[15])));
    chk({tp, " prg_addr"}, 32'(prg_addr), 32'(e_prg_addr()));
    chk({tc, " chr_ram_cs"}, 32'(chr_ram_cs), 32'(!m_game && !ppu_addr[13]));
    chk({tc, " chr_ram_we"}, 32'(chr_ram_we), 32'(!m_game && !ppu_addr[13] && ppu_wr));
    chk({tc, " game_chr_cs"}, 32'(game_chr_cs), 32'(e_gcs(!ppu_addr[13])));
    chk({tc, " chr_addr"}, 32'(chr_addr), 32'(e_chr_addr()));
  endtask

  task automatic access(logic [15:0] ca, logic [13:0] pa, bit pw,
                        logic [3:0] ip, logic [6:0] ic);
    @(negedge clk);
    cpu_addr = ca; ppu_addr = pa; ppu_wr = pw; inner_prg = ip; inner_chr = ic;
    #1;
    if (m_game) check_outputs("R7", "R8");
    else        check_outputs("R5", "R6");
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(posedge clk);
    if (a[15:13] == 3'b011 && !m_game) begin
      m_game = d[4];
      m_bank = d[2:0];
    end
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_game = 0; m_bank = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // observe state: mode via menu_cs, bank via chip select and address
  task automatic probe(string tag);
    @(negedge clk);
    cpu_addr = 16'h9234; ppu_addr = 14'h0567; ppu_wr = 1'b0;
    #1;
    chk({tag, " mode"}, 32'(menu_cs), 32'(!m_game));
    chk({tag, " bank"}, 32'({game_prg_cs, prg_addr[18:17]}),
        32'({e_gcs(1'b1), m_game ? m_bank[1:0] : 2'b00}));
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    // R1 reset state
    cpu_addr = 16'h8000; ppu_addr = 14'h0000;
    #1;
    chk("R1 reset menu_cs", 32'(menu_cs), 32'd1);
    chk("R1 reset chr_ram_cs", 32'(chr_ram_cs), 32'd1);
    chk("R1 reset game_prg_cs", 32'(game_prg_cs), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R2: writes just outside the window
    cpu_write(16'h5FFF, 8'h17);
    probe("R2 below window");
    cpu_write(16'h8000, 8'h16);
    probe("R2 above window");
    // R3: ignored data bits, menu write keeps unlocked
    cpu_write(16'h7FFF, 8'hE8 | 8'h05);
    probe("R3 ignored bits");
    // R3/R4: game write at window start locks bank 6
    cpu_write(16'h6000, 8'hF6);
    probe("R3 game capture");
    cpu_write(16'h6ABC, 8'h11);
    probe("R4 locked");
    cpu_write(16'h7000, 8'h03);
    probe("R4 locked menu write");
    access(16'hC123, 14'h1ABC, 1'b1, 4'hA, 7'h55);
    access(16'h4123, 14'h2ABC, 1'b1, 4'h3, 7'h2A);
    // R1: reset clears the lock
    do_reset();
    probe("R1 after reset");
    access(16'hFFFF, 14'h1FFF, 1'b1, 4'hF, 7'h7F);
    cpu_write(16'h6001, 8'h12);
    probe("R3 bank 2");
    access(16'h8001, 14'h03FF, 1'b0, 4'h1, 7'h01);

    // constrained random phase
    for (int i = 0; i < 600; i++) begin
      int sel = $urandom_range(0, 99);
      if (sel < 3) begin
        do_reset();
      end else if (sel < 25) begin
        logic [15:0] a = 16'($urandom);
        if ($urandom_range(0, 2) != 0) a[15:13] = 3'b011;
        cpu_write(a, 8'($urandom));
      end else begin
        access(16'($urandom), 14'($urandom), 1'($urandom),
               4'($urandom), 7'($urandom));
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule